// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit with Carry

This block is the shift datapath of a small 32-bit integer core. It takes one operand, a shift count and a three-bit operation code, and in the same cycle produces the shifted result, the next value of the condition carry flag and a strobe that says whether that flag is to be written. Four operations take their count from a whole register value. Four take it from a short immediate field. An immediate count of zero does not mean "no shift": it selects a shift by one position that passes through the carry flag.

All shifting and rotating shares one logarithmic right-shifter. Left-going operations mirror the operand bit order on the way in and on the way out. The block holds no state. The surrounding core decodes the instruction word, reads the register file and commits the result.

Top module: `shf_rot_unit`

## Requirements
- R1: With op 0 (logical right, register count), the result is the operand shifted right with zero fill by the register count when that count is 31 or less. It is 0 when the count is 32 or more, with any of bits 31..5 set.
- R2: With op 1 (logical left, register count), the result is the operand shifted left with zero fill by the register count when that count is 31 or less. It is 0 when the count is 32 or more.
- R3: With op 2 (arithmetic right, register count), the result is the operand shifted right with copies of bit 31 filled in when the count is 31 or less. For a count of 32 or more it is all ones if bit 31 is set and 0 if it is clear.
- R4: With op 3 (bit generate), the result has exactly one bit set, at the position given by count bits 4..0, when count bit 5 is clear. It is 0 when count bit 5 is set. Count bits 31..6 have no effect.
- R5: With op 4, 5 or 6 (logical right, logical left, arithmetic right) and a nonzero immediate n in 1..31, the result is the operand shifted by n. carry_we_o is low and carry_o equals carry_i.
- R6: With op 7 and a nonzero immediate n, the result is the operand rotated left by n, that is (x << n) | (x >> (32 - n)). carry_we_o is low.
- R7: With op 7 and an immediate of 0, the result is the operand rotated right by one through carry: bit 31 takes the old carry and bits 30..0 take operand bits 31..1. carry_o is operand bit 0 and carry_we_o is high.
- R8: With op 4, 5 or 6 and an immediate of 0, the operand is shifted by exactly one position. carry_o is the bit shifted out (bit 0 for ops 4 and 6, bit 31 for op 5) and carry_we_o is high.
- R9: The register-count operations (ops 0 to 3) never write carry. carry_we_o is low and carry_o equals carry_i. The immediate input has no effect on their result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted or rotated |
| amt_reg_i | input | 32 | Full register shift count (ops 0 to 3) |
| amt_imm_i | input | 5 | Immediate shift count (ops 4 to 7) |
| op_i | input | 3 | Operation code: 0 LSR reg, 1 LSL reg, 2 ASR reg, 3 bit generate, 4 LSR imm, 5 LSL imm, 6 ASR imm, 7 rotate-left imm |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shift or rotate result |
| carry_o | output | 1 | Next carry flag value |
| carry_we_o | output | 1 | Carry write enable |

## Verification
Every operation code is swept across all 32 immediate counts, or across register counts 0 to 36 plus large values such as 0x40, 0x100 and 0x80000000. Each sweep is repeated for both carry values and for six operands. The operands are alternating bit patterns, a lone sign bit, a lone low bit, all ones and a mixed word. They separate zero fill from sign fill and expose a wrong wrap source in a rotate. Counts at 31, 32 and 33 tell a saturating shift from one that wraps the count modulo 32. The large counts show that bit generate looks only at bit 5 among the upper bits. An immediate of zero under both carry values is what tells the through-carry by-one path apart from a shift that does nothing.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [2:0] {
      SOP_LSR_REG  = 3'd0,
      SOP_LSL_REG  = 3'd1,
      SOP_ASR_REG  = 3'd2,
      SOP_BGEN_REG = 3'd3,
      SOP_LSR_IMM  = 3'd4,
      SOP_LSL_IMM  = 3'd5,
      SOP_ASR_IMM  = 3'd6,
      SOP_ROTL_IMM = 3'd7
   } shf_op_e;

   typedef struct packed {
      logic left;    // operation moves bits toward the MSB
      logic rotate;  // wrap instead of fill
      logic arith;   // fill with sign bit
      logic imm;     // count comes from the immediate field
      logic bgen;    // single-bit generate
   } shf_ctl_t;

   function automatic shf_ctl_t shf_decode(shf_op_e op);
      shf_ctl_t c;
      c = '0;
      unique case (op)
         SOP_LSR_REG:  c = '0;
         SOP_LSL_REG:  c.left = 1'b1;
         SOP_ASR_REG:  c.arith = 1'b1;
         SOP_BGEN_REG: c.bgen = 1'b1;
         SOP_LSR_IMM:  c.imm = 1'b1;
         SOP_LSL_IMM:  begin c.imm = 1'b1; c.left = 1'b1; end
         SOP_ASR_IMM:  begin c.imm = 1'b1; c.arith = 1'b1; end
         SOP_ROTL_IMM: begin c.imm = 1'b1; c.left = 1'b1; c.rotate = 1'b1; end
         default:      c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/shf_amount_dec.sv
module shf_amount_dec #(
   parameter int W  = 32,
   parameter int AW = $clog2(W)
) (
   input  logic          is_imm_i,
   input  logic [W-1:0]  amt_reg_i,
   input  logic [AW-1:0] amt_imm_i,
   output logic [AW-1:0] amt_o,
   output logic          sat_o,
   output logic          by_one_o
);

   logic imm_zero;

   assign imm_zero = (amt_imm_i == '0);
   assign by_one_o = is_imm_i & imm_zero;
   assign sat_o    = ~is_imm_i & (|amt_reg_i[W-1:AW]);

   always_comb begin
      if (!is_imm_i)
         amt_o = amt_reg_i[AW-1:0];
      else if (imm_zero)
         amt_o = AW'(1);
      else
         amt_o = amt_imm_i;
   end

   // R8
   always_comb begin
      if (by_one_o)
         by_one_amt_chk: assert (amt_o == AW'(1))
            else $error("zero immediate did not become a count of one");
   end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
   parameter int W  = 32,
   parameter int AW = $clog2(W)
) (
   input  logic [W-1:0]  data_i,
   input  logic [AW-1:0] amt_i,
   input  logic          fill_i,
   input  logic          rot_i,
   output logic [W-1:0]  data_o
);

   logic [W-1:0] stg [AW+1];

   assign stg[0] = data_i;

   for (genvar k = 0; k < AW; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [S-1:0] top_bits;
      assign top_bits   = rot_i ? stg[k][S-1:0] : {S{fill_i}};
      assign stg[k+1]   = amt_i[k] ? {top_bits, stg[k][W-1:S]} : stg[k];
   end

   assign data_o = stg[AW];

   // R6
   always_comb begin
      if (rot_i)
         rot_popcount_chk: assert ($countones(data_o) == $countones(data_i))
            else $error("rotate changed the number of set bits");
   end

endmodule

// File: rtl/shf_carry_sel.sv
module shf_carry_sel #(
   parameter int W = 32
) (
   input  logic         by_one_i,
   input  logic         left_i,
   input  logic [W-1:0] opnd_i,
   input  logic         carry_i,
   output logic         carry_o,
   output logic         carry_we_o
);

   assign carry_we_o = by_one_i;

   always_comb begin
      if (!by_one_i)
         carry_o = carry_i;
      else if (left_i)
         carry_o = opnd_i[W-1];
      else
         carry_o = opnd_i[0];
   end

endmodule

// File: rtl/shf_rot_unit.sv
module shf_rot_unit #(
   parameter int W  = 32,
   localparam int AW = $clog2(W)
) (
   input  logic [W-1:0]  opnd_i,
   input  logic [W-1:0]  amt_reg_i,
   input  logic [AW-1:0] amt_imm_i,
   input  logic [2:0]    op_i,
   input  logic          carry_i,
   output logic [W-1:0]  result_o,
   output logic          carry_o,
   output logic          carry_we_o
);
   import shf_pkg::*;

   if (W < 8) begin : g_bad_small
      $error("shf_rot_unit: W must be at least 8");
   end
   if ((1 << AW) != W) begin : g_bad_pow2
      $error("shf_rot_unit: W must be a power of two");
   end

   shf_ctl_t       ctl;
   logic [AW-1:0]  amt;
   logic           sat;
   logic           by_one;
   logic           left_eff;
   logic           rot_eff;
   logic           rrc;
   logic           fill;
   logic [W-1:0]   core_in;
   logic [W-1:0]   core_out;
   logic [W-1:0]   core_rev;
   logic [W-1:0]   opnd_rev;
   logic [W-1:0]   shifted;
   logic [W-1:0]   bgen_vec;

   assign ctl = shf_decode(shf_op_e'(op_i));

   shf_amount_dec #(.W(W), .AW(AW)) amt_dec_i (
      .is_imm_i  (ctl.imm),
      .amt_reg_i (amt_reg_i),
      .amt_imm_i (amt_imm_i),
      .amt_o     (amt),
      .sat_o     (sat),
      .by_one_o  (by_one)
   );

   // zero-count rotate turns into a right rotate through carry
   assign rrc      = ctl.rotate & by_one;
   assign left_eff = ctl.left & ~rrc;
   assign rot_eff  = ctl.rotate & ~by_one;
   assign fill     = rrc ? carry_i : (ctl.arith & opnd_i[W-1]);

   for (genvar i = 0; i < W; i++) begin : g_mirror
      assign opnd_rev[i] = opnd_i[W-1-i];
      assign core_rev[i] = core_out[W-1-i];
   end

   assign core_in = left_eff ? opnd_rev : opnd_i;

   shf_barrel #(.W(W), .AW(AW)) barrel_i (
      .data_i (core_in),
      .amt_i  (amt),
      .fill_i (fill),
      .rot_i  (rot_eff),
      .data_o (core_out)
   );

   assign shifted = left_eff ? core_rev : core_out;

   for (genvar i = 0; i < W; i++) begin : g_bgen
      assign bgen_vec[i] = ~amt_reg_i[AW] & (amt_reg_i[AW-1:0] == AW'(i));
   end

   always_comb begin
      if (ctl.bgen)
         result_o = bgen_vec;
      else if (sat)
         result_o = {W{fill}};
      else
         result_o = shifted;
   end

   shf_carry_sel #(.W(W)) carry_sel_i (
      .by_one_i   (by_one),
      .left_i     (left_eff),
      .opnd_i     (opnd_i),
      .carry_i    (carry_i),
      .carry_o    (carry_o),
      .carry_we_o (carry_we_o)
   );

   // R4
   always_comb begin
      if (ctl.bgen)
         bgen_onehot_chk: assert ($onehot0(result_o))
            else $error("bit generate set more than one bit");
   end

   // R9
   always_comb begin
      if (!carry_we_o)
         carry_hold_chk: assert (carry_o == carry_i)
            else $error("carry changed without write enable");
   end

   // R1
   always_comb begin
      if (!ctl.imm && !ctl.arith && !ctl.bgen && (|amt_reg_i[W-1:AW]))
         sat_zero_chk: assert (result_o == '0)
            else $error("oversized logical shift not zero");
   end

   // R7
   always_comb begin
      if (ctl.rotate && (amt_imm_i == '0))
         rrc_path_chk: assert (result_o[W-1] == carry_i && carry_o == opnd_i[0] && carry_we_o)
            else $error("rotate through carry mismatch");
   end

   // R5
   always_comb begin
      if (ctl.imm && (amt_imm_i != '0))
         imm_nowe_chk: assert (!carry_we_o)
            else $error("nonzero immediate wrote carry");
   end

endmodule

// File: tb/shf_rot_unit_tb.sv
module shf_rot_unit_tb_top;

   logic        clk = 1'b0;
   logic [31:0] opnd = '0;
   logic [31:0] amt_reg = '0;
   logic [4:0]  amt_imm = '0;
   logic [2:0]  op = '0;
   logic        cin = 1'b0;
   logic [31:0] res;
   logic        cout;
   logic        cwe;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;   // 8 ns period

   shf_rot_unit dut_i (
      .opnd_i     (opnd),
      .amt_reg_i  (amt_reg),
      .amt_imm_i  (amt_imm),
      .op_i       (op),
      .carry_i    (cin),
      .result_o   (res),
      .carry_o    (cout),
      .carry_we_o (cwe)
   );

   function automatic logic [31:0] pat(int p);
      case (p)
         0: return 32'hAAAA_5555;
         1: return 32'h8000_0000;
         2: return 32'h0000_0001;
         3: return 32'hFFFF_FFFF;
         4: return 32'h1234_5678;
         default: return 32'hC03F_0A91;
      endcase
   endfunction

   function automatic logic [31:0] ramt(int a);
      if (a <= 36) return 32'(a);
      case (a)
         37: return 32'h0000_0040;
         38: return 32'h0000_0100;
         39: return 32'h8000_0000;
         default: return 32'h0000_0021;
      endcase
   endfunction

   task automatic check(input logic [31:0] er, input logic ec, input logic ew, input string tag);
      n_run++;
      if (res !== er || cout !== ec || cwe !== ew) begin
         n_fail++;
         $display("FAIL %s op=%0d x=%h reg=%h imm=%0d c=%0b: got r=%h c=%0b we=%0b exp r=%h c=%0b we=%0b",
                  tag, op, opnd, amt_reg, amt_imm, cin, res, cout, cwe, er, ec, ew);
      end
   endtask

   task automatic run_one();
      logic [31:0] er;
      logic        ec;
      logic        ew;
      string       tag;
      int          n;
      ec = cin;
      ew = 1'b0;
      er = '0;
      n  = (amt_imm == 0) ? 1 : int'(amt_imm);
      case (op)
         3'd0: begin tag = "R1/R9"; er = (amt_reg > 31) ? 32'h0 : (opnd >> amt_reg); end
         3'd1: begin tag = "R2/R9"; er = (amt_reg > 31) ? 32'h0 : (opnd << amt_reg); end
         3'd2: begin
            tag = "R3/R9";
            if (amt_reg > 31) er = opnd[31] ? 32'hFFFF_FFFF : 32'h0;
            else er = 32'($signed(opnd) >>> amt_reg);
         end
         3'd3: begin tag = "R4/R9"; er = amt_reg[5] ? 32'h0 : (32'h1 << amt_reg[4:0]); end
         3'd4, 3'd5, 3'd6: begin
            if (op == 3'd4) er = opnd >> n;
            else if (op == 3'd5) er = opnd << n;
            else er = 32'($signed(opnd) >>> n);
            if (amt_imm == 0) begin
               tag = "R8"; ew = 1'b1;
               ec = (op == 3'd5) ? opnd[31] : opnd[0];
            end else tag = "R5";
         end
         default: begin
            if (amt_imm == 0) begin
               tag = "R7"; er = {cin, opnd[31:1]}; ec = opnd[0]; ew = 1'b1;
            end else begin
               tag = "R6"; er = (opnd << n) | (opnd >> (32 - n));
            end
         end
      endcase
      @(negedge clk);
      check(er, ec, ew, tag);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      // all-zero inputs: logical right of zero gives zero, carry held
      check(32'h0, 1'b0, 1'b0, "R1");
      for (int o = 0; o < 8; o++) begin
         for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 2; c++) begin
               if (o < 4) begin
                  for (int a = 0; a <= 40; a++) begin
                     @(posedge clk);
                     op = 3'(o); opnd = pat(p); cin = c[0];
                     amt_reg = ramt(a);
                     amt_imm = 5'(a + 7);   // must not matter (R9)
                     run_one();
                  end
               end else begin
                  for (int a = 0; a < 32; a++) begin
                     @(posedge clk);
                     op = 3'(o); opnd = pat(p); cin = c[0];
                     amt_imm = 5'(a);
                     amt_reg = 32'hFFFF_FFC0 | 32'(a);  // must not matter
                     run_one();
                  end
               end
            end
         end
      end
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule